// File: doc/BRIEF.md
# Tagged Sample Queue for a DAC Sequencer

This block sits between a register write port and the conversion sequencer of a digital-to-analog converter. Each 32-bit write to the conversion data register is split into 16-bit half-words. Every half-word becomes one queue entry that holds a 12-bit sample and a 2-bit output channel number. The queue holds four entries. The sequencer drains it through a valid/pop interface and always sees the oldest entry at the head.

Two mode inputs, sampled on the write cycle, decide how a write is interpreted. Word mode controls whether a write queues the low half-word only or both half-words, low half first. Tag mode controls where the channel comes from: either from a channel field carried inside each half-word, or from a single channel-select input shared by all entries.

A ready output tells software whether a write can be taken. It requires the sequencer to be ready and enough free space for the whole write. A write made while ready is low is refused, and it raises a sticky flag. A synchronous soft reset empties the queue and clears that flag.

Top module: `dac_tag_fifo`

## Requirements
- R1: After reset the queue is empty (`entry_valid` low), `overflow` is low and `tx_ready` is high while `ctrl_ready` is high. The queue holds exactly four entries.
- R2: In half-word mode (`word_mode`=0), an accepted write adds one entry. Its sample is `wr_data[11:0]`. Bits [15:14] and [31:16] have no effect.
- R3: In word mode (`word_mode`=1), an accepted write adds two entries. The first holds sample `wr_data[11:0]` and the second holds sample `wr_data[27:16]`, and they leave the queue in that order.
- R4: With `tag_mode`=0, every entry's channel is `user_chan` as sampled on the write cycle. The tag bits in the data are ignored.
- R5: With `tag_mode`=1, the first half-word takes its channel from `wr_data[13:12]`. The second half-word in word mode takes its channel from `wr_data[29:28]`.
- R6: `tx_ready` is low whenever `ctrl_ready` is low.
- R7: `tx_ready` requires at least one free entry in half-word mode and at least two free entries in word mode.
- R8: A write while `tx_ready` is low stores nothing, leaves the queued entries unchanged, and sets `overflow`. `overflow` stays set until a soft reset.
- R9: `soft_rst` empties the queue and clears `overflow` on the next clock edge. It takes priority over a write in the same cycle.
- R10: `pop` removes the head entry when `entry_valid` is high. A pop on an empty queue has no effect. A write and a pop in the same cycle are both carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of queue and overflow flag |
| ctrl_ready | input | 1 | Sequencer is able to accept requests |
| word_mode | input | 1 | 1: a write queues both half-words; 0: low half-word only |
| tag_mode | input | 1 | 1: channel taken from tag bits in the data; 0: from user_chan |
| user_chan | input | 2 | Shared channel select used when tag_mode is 0 |
| wr_en | input | 1 | Write strobe for the conversion data register |
| wr_data | input | 32 | Written data |
| tx_ready | output | 1 | A write is accepted this cycle |
| overflow | output | 1 | Sticky: a write was made while tx_ready was low |
| entry_valid | output | 1 | Head entry present |
| entry_sample | output | 12 | Head entry sample |
| entry_chan | output | 2 | Head entry channel |
| pop | input | 1 | Remove the head entry |

## Verification
The bench runs every combination of the two mode inputs with data whose tag bits and unused bits are deliberately non-zero. A design that takes the channel from the wrong field, or swaps the two half-words, would pop entries with the wrong channel or in the wrong order.

The bench fills the queue to three entries and then issues a word write. The queue has room for one more half-word but not two. A design that checks for only one free slot would accept the write and corrupt the queued data, or would drop the second half.

The bench also pops an empty queue and then pushes and pops in the same cycle. These steps expose an occupancy count that underflows, or that misses one of the two updates.

// File: rtl/dac_tag_fifo.sv
module dac_tag_fifo #(
  parameter int DEPTH    = 4,
  parameter int DATA_W   = 32,
  parameter int SAMPLE_W = 12,
  parameter int CHAN_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                ctrl_ready,
  input  logic                word_mode,
  input  logic                tag_mode,
  input  logic [CHAN_W-1:0]   user_chan,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                tx_ready,
  output logic                overflow,
  output logic                entry_valid,
  output logic [SAMPLE_W-1:0] entry_sample,
  output logic [CHAN_W-1:0]   entry_chan,
  input  logic                pop
);

  localparam int HALF_W = DATA_W / 2;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = AW + 1;
  localparam int ENT_W  = CHAN_W + SAMPLE_W;

  initial begin
    assert (DEPTH >= 2 && (1 << AW) == DEPTH && SAMPLE_W + CHAN_W <= HALF_W)
      else $error("dac_tag_fifo: unsupported parameters");
  end

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, free_cnt, n_push;
  logic [HALF_W-1:0] half_lo, half_hi;
  logic [ENT_W-1:0] ent_lo, ent_hi;
  logic accept, reject, do_pop;

  assign half_lo  = wr_data[HALF_W-1:0];
  assign half_hi  = wr_data[DATA_W-1:HALF_W];
  assign ent_lo   = {tag_mode ? half_lo[SAMPLE_W +: CHAN_W] : user_chan, half_lo[SAMPLE_W-1:0]};
  assign ent_hi   = {tag_mode ? half_hi[SAMPLE_W +: CHAN_W] : user_chan, half_hi[SAMPLE_W-1:0]};

  assign free_cnt = CW'(DEPTH) - count;
  assign tx_ready = ctrl_ready && (word_mode ? (free_cnt >= CW'(2)) : (free_cnt >= CW'(1)));
  assign accept   = wr_en && tx_ready;
  assign reject   = wr_en && !tx_ready;
  assign do_pop   = pop && entry_valid;
  assign n_push   = !accept ? CW'(0) : (word_mode ? CW'(2) : CW'(1));

  assign entry_valid  = (count != '0);
  assign entry_sample = mem[rd_ptr][SAMPLE_W-1:0];
  assign entry_chan   = mem[rd_ptr][ENT_W-1:SAMPLE_W];

  always_ff @(posedge clk) begin
    if (accept && !soft_rst) begin
      mem[wr_ptr] <= ent_lo;
      if (word_mode) mem[wr_ptr + AW'(1)] <= ent_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (soft_rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      wr_ptr   <= wr_ptr + AW'(n_push);
      rd_ptr   <= rd_ptr + AW'(do_pop);
      count    <= count + n_push - CW'(do_pop);
      overflow <= overflow | reject;
    end
  end

  p_count_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_half_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !word_mode && !pop && !soft_rst |=> count == $past(count) + CW'(1));

  p_word_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && word_mode && !pop && !soft_rst |=> count == $past(count) + CW'(2));

  p_no_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && word_mode && count > CW'(DEPTH - 2) && !pop && !soft_rst |=> $stable(count) && $stable(wr_ptr));

  p_reject_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject && !pop && !soft_rst |=> $stable(count) && overflow);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !soft_rst |=> overflow);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !entry_valid && !overflow);

  p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_valid && !wr_en && !soft_rst |=> !entry_valid);

endmodule

// File: tb/dac_tag_fifo_tb.sv
`timescale 1ns/1ps
module dac_tag_fifo_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, ctrl_ready = 1'b1, word_mode = 1'b0, tag_mode = 1'b0;
  logic [1:0] user_chan = 2'd0;
  logic wr_en = 1'b0, pop = 1'b0;
  logic [31:0] wr_data = '0;
  logic tx_ready, overflow, entry_valid;
  logic [11:0] entry_sample;
  logic [1:0] entry_chan;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_tag_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctrl_ready(ctrl_ready),
    .word_mode(word_mode), .tag_mode(tag_mode), .user_chan(user_chan),
    .wr_en(wr_en), .wr_data(wr_data), .tx_ready(tx_ready), .overflow(overflow),
    .entry_valid(entry_valid), .entry_sample(entry_sample), .entry_chan(entry_chan),
    .pop(pop)
  );

  // {word, tag, user_chan, data, first {chan,sample}, second {chan,sample}}
  localparam logic [63:0] VEC [6] = '{
    {1'b0, 1'b0, 2'd2, 32'hFFFF_3ABC, 2'd2, 12'hABC, 14'd0},
    {1'b0, 1'b1, 2'd0, 32'h0000_E123, 2'd2, 12'h123, 14'd0},
    {1'b1, 1'b0, 2'd1, 32'h5678_9ABC, 2'd1, 12'hABC, 2'd1, 12'h678},
    {1'b1, 1'b1, 2'd3, 32'h1234_C456, 2'd0, 12'h456, 2'd1, 12'h234},
    {1'b1, 1'b1, 2'd0, 32'hF000_3FFF, 2'd3, 12'hFFF, 2'd3, 12'h000},
    {1'b0, 1'b1, 2'd1, 32'h7777_0001, 2'd0, 12'h001, 14'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic do_write(input logic wm, input logic tm, input logic [1:0] us, input logic [31:0] d);
    @(negedge clk);
    word_mode = wm; tag_mode = tm; user_chan = us; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [1:0] ch, input logic [11:0] s);
    check({req, " valid"}, int'(entry_valid), 1);
    check({req, " sample"}, int'(entry_sample), int'(s));
    check({req, " chan"}, int'(entry_chan), int'(ch));
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset entry_valid", int'(entry_valid), 0);
    check("R1 reset overflow", int'(overflow), 0);
    check("R1 reset tx_ready", int'(tx_ready), 1);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic [63:0] v;
      v = VEC[i];
      do_write(v[63], v[62], v[61:60], v[59:28]);
      pop_expect(v[63] ? "R3/R5/R4 first" : "R2/R4/R5 single", v[27:26], v[25:14]);
      if (v[63]) pop_expect("R3/R5/R4 second", v[13:12], v[11:0]);
      check("R2 R3 entry count after drain", int'(entry_valid), 0);
    end

    // R6 ctrl not ready blocks
    @(negedge clk);
    ctrl_ready = 1'b0; word_mode = 1'b0;
    #1 check("R6 tx_ready with ctrl not ready", int'(tx_ready), 0);
    do_write(1'b0, 1'b0, 2'd1, 32'h0000_0555);
    check("R8 overflow after refused write", int'(overflow), 1);
    check("R8 nothing stored", int'(entry_valid), 0);
    ctrl_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 overflow sticky", int'(overflow), 1);
    flush();
    check("R9 overflow cleared", int'(overflow), 0);

    // R7 room rules with three entries queued
    do_write(1'b0, 1'b0, 2'd0, 32'h0000_0101);
    do_write(1'b0, 1'b0, 2'd1, 32'h0000_0202);
    do_write(1'b0, 1'b0, 2'd2, 32'h0000_0303);
    word_mode = 1'b0;
    #1 check("R7 halfword ready with one free", int'(tx_ready), 1);
    word_mode = 1'b1;
    #1 check("R7 word not ready with one free", int'(tx_ready), 0);
    do_write(1'b1, 1'b1, 2'd0, 32'h3AAA_3BBB);
    check("R8 overflow on word write without room", int'(overflow), 1);
    pop_expect("R8 contents kept 0", 2'd0, 12'h101);
    pop_expect("R8 contents kept 1", 2'd1, 12'h202);
    pop_expect("R8 contents kept 2", 2'd2, 12'h303);
    check("R8 no extra entry", int'(entry_valid), 0);
    flush();

    // R1 depth four
    for (int k = 0; k < 4; k++) do_write(1'b0, 1'b0, 2'd3, 32'(k + 16));
    word_mode = 1'b0;
    #1 check("R1 full after four", int'(tx_ready), 0);
    // R9 soft reset empties
    flush();
    check("R9 flushed empty", int'(entry_valid), 0);
    check("R9 ready after flush", int'(tx_ready), 1);

    // R9 soft reset beats a write
    @(negedge clk);
    word_mode = 1'b0; wr_data = 32'h0000_0777; wr_en = 1'b1; soft_rst = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; soft_rst = 1'b0;
    check("R9 write dropped under soft reset", int'(entry_valid), 0);

    // R10 pop on empty
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    check("R10 pop empty stays empty", int'(entry_valid), 0);
    do_write(1'b0, 1'b0, 2'd1, 32'h0000_0ABC);
    pop_expect("R10 after empty pop", 2'd1, 12'hABC);
    check("R10 no underflow", int'(entry_valid), 0);

    // R10 push and pop in one cycle
    do_write(1'b0, 1'b0, 2'd2, 32'h0000_0111);
    @(negedge clk);
    wr_data = 32'h0000_0222; user_chan = 2'd3; wr_en = 1'b1; pop = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pop = 1'b0;
    pop_expect("R10 simultaneous", 2'd3, 12'h222);
    check("R10 simultaneous empty after", int'(entry_valid), 0);

    finish_run();
  end
endmodule